// File: doc/BRIEF.md
# Device-Side Address Translation Cache

This block sits inside an I/O function, on the path its DMA requests take toward the host. It keeps a small, fully associative set of recent mappings from untranslated I/O page numbers to host physical page numbers. Each outgoing DMA request is looked up in the same cycle it is offered. On a usable hit the request leaves with the physical page number and the original page offset, and is tagged as translated. Otherwise it leaves with the address it came in with, tagged as untranslated. A miss can also emit a translation request toward the host-side agent.

The cache is filled only by translation completions from the host. A successful completion installs a mapping with read and write permission bits, or updates one that is already cached. A failed completion installs a marker that no translation exists for that page. The marker keeps later requests for that page untranslated and stops them from asking the host again. A pending table allows one outstanding translation request per page. An invalidate-all input empties the cache and the pending table in one cycle.

The default configuration has 8 entries, 4 KiB pages (12 offset bits), 36-bit page numbers on both sides (a 48-bit address), 4 pending slots, and round-robin replacement.

Top module: `xlat_cache`

## Requirements
- R1: After reset, outValid and xreqValid are 0, reqReady is 1, and the cache holds no entries.
- R2: A request whose page holds a usable entry is forwarded one cycle after acceptance with outAddr = {cached physical page, reqAddr[11:0]} and outTranslated = 1. No translation request is raised for it.
- R3: A request whose page has no entry and no pending request is forwarded with outAddr equal to reqAddr and outTranslated = 0. In the same cycle xreqValid rises with xreqVpn = reqAddr[47:12].
- R4: While a translation request for a page is outstanding, that is, until a completion for that page arrives, further misses on the page are forwarded untranslated and raise no new translation request.
- R5: A completion with cplOk = 0 records that no translation exists. Later requests for that page go out untranslated and raise no translation request.
- R6: A write that hits an entry without write permission, or a read that hits an entry without read permission, goes out untranslated and raises no translation request.
- R7: A completion for a page that is already cached updates that entry in place. It evicts no other entry and does not move the replacement pointer.
- R8: A completion for an uncached page fills the entry at a round-robin pointer that starts at entry 0, advances by one for each new fill, and wraps after the last entry. Invalidate-all returns the pointer to entry 0.
- R9: invalAll clears every entry and every pending slot in one cycle. A completion in the same cycle is discarded. A request accepted in the same cycle is treated as a miss.
- R10: The forwarded request is registered. While outValid = 1 and outReady = 0, the forwarded request stays unchanged. reqReady is 0 whenever a registered output is held by backpressure.
- R11: While xreqValid = 1 and xreqReady = 0, xreqValid stays 1 and xreqVpn stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Incoming DMA request valid |
| reqReady | output | 1 | Block can accept an incoming request |
| reqAddr | input | 48 | Untranslated request address |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| outValid | output | 1 | Forwarded request valid |
| outReady | input | 1 | Downstream accepts the forwarded request |
| outAddr | output | 48 | Forwarded address, translated or not |
| outWrite | output | 1 | Forwarded read/write flag |
| outTranslated | output | 1 | 1 when outAddr carries a physical page |
| xreqValid | output | 1 | Translation request toward the host valid |
| xreqReady | input | 1 | Host side accepts the translation request |
| xreqVpn | output | 36 | Page number to be translated |
| cplValid | input | 1 | Translation completion valid |
| cplVpn | input | 36 | Page number the completion refers to |
| cplOk | input | 1 | 1 = translation granted, 0 = no translation |
| cplPpn | input | 36 | Granted physical page number |
| cplRead | input | 1 | Read permission granted |
| cplWrite | input | 1 | Write permission granted |
| invalAll | input | 1 | Drop every cached and pending translation |

## Verification
The bench sweeps every entry of the cache through fill, wrap-around eviction and in-place update, and varies the page offsets. A design that advanced the pointer on an update would evict the wrong page. A design that started the pointer at the wrong entry would lose a page other than the first one filled. A request repeated on a page with a request outstanding must not ask the host again, and a recorded failure must not be retried. Permission-denied hits must leave untranslated and without a host request. The invalidate corners are checked as well: a completion in the same cycle as an invalidate must not survive, a request in the same cycle must miss, and a request outstanding before an invalidate must be asked again after it. Backpressure on both outputs must freeze them and stall the input; a design that let data through would corrupt the held request.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Strobes the control unit issues to the datapath each cycle
  typedef struct packed {
    logic accept;     // load the forwarded-request register
    logic useXlat;    // forwarded request carries the cached page
    logic issueXreq;  // load the translation-request register
    logic allocPend;  // reserve a pending slot for the request page
    logic install;    // write the completion into the cache
    logic clearAll;   // drop every entry and pending slot
  } ctrl_strobe_t;

endpackage

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
#(
  parameter int unsigned NUM_ENT  = 8,
  parameter int unsigned NUM_PEND = 4,
  parameter int unsigned PN_W     = 36,
  parameter int unsigned OFF_W    = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_strobe_t            strobe,
  input  logic [PN_W+OFF_W-1:0]   reqAddr,
  input  logic                    reqWrite,
  input  logic [PN_W-1:0]         cplVpn,
  input  logic                    cplOk,
  input  logic [PN_W-1:0]         cplPpn,
  input  logic                    cplRead,
  input  logic                    cplWrite,
  output logic                    tagHit,
  output logic                    usable,
  output logic                    pendHit,
  output logic                    pendFull,
  output logic [PN_W+OFF_W-1:0]   outAddr,
  output logic                    outWrite,
  output logic                    outTranslated,
  output logic [PN_W-1:0]         xreqVpn
);

  localparam int unsigned ADDR_W = PN_W + OFF_W;
  localparam int unsigned PTR_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int unsigned PIDX_W = (NUM_PEND > 1) ? $clog2(NUM_PEND) : 1;

  // Entry storage
  logic [NUM_ENT-1:0] entValid;
  logic [NUM_ENT-1:0] entNoX;
  logic [NUM_ENT-1:0] entR;
  logic [NUM_ENT-1:0] entW;
  logic [PN_W-1:0]    entTag [NUM_ENT];
  logic [PN_W-1:0]    entPpn [NUM_ENT];
  logic [PTR_W-1:0]   rrPtr;

  // Pending translation requests
  logic [NUM_PEND-1:0] pendValid;
  logic [PN_W-1:0]     pendVpn [NUM_PEND];

  logic [PN_W-1:0]     reqVpn;
  logic [NUM_ENT-1:0]  hitVec;
  logic [NUM_ENT-1:0]  cplMatch;
  logic [NUM_PEND-1:0] pendMatch;
  logic [NUM_PEND-1:0] pendCplMatch;

  assign reqVpn = reqAddr[ADDR_W-1:OFF_W];

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : gEntCmp
      assign hitVec[g]   = entValid[g] && (entTag[g] == reqVpn);
      assign cplMatch[g] = entValid[g] && (entTag[g] == cplVpn);
    end
    for (g = 0; g < NUM_PEND; g++) begin : gPendCmp
      assign pendMatch[g]    = pendValid[g] && (pendVpn[g] == reqVpn);
      assign pendCplMatch[g] = pendValid[g] && (pendVpn[g] == cplVpn);
    end
  endgenerate

  // Read out the matching entry (tags are kept unique)
  logic [PN_W-1:0] selPpn;
  logic            selNoX;
  logic            selR;
  logic            selW;

  always_comb begin
    selPpn = '0;
    selNoX = 1'b0;
    selR   = 1'b0;
    selW   = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (hitVec[i]) begin
        selPpn = selPpn | entPpn[i];
        selNoX = selNoX | entNoX[i];
        selR   = selR | entR[i];
        selW   = selW | entW[i];
      end
    end
  end

  assign tagHit   = |hitVec;
  assign usable   = !selNoX && (reqWrite ? selW : selR);
  assign pendHit  = |pendMatch;
  assign pendFull = &pendValid;

  // Completion target: the matching entry, else the round-robin victim
  logic             cplAny;
  logic [PTR_W-1:0] cplIdx;
  logic [PTR_W-1:0] fillIdx;

  always_comb begin
    cplAny = 1'b0;
    cplIdx = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (cplMatch[i]) begin
        cplAny = 1'b1;
        cplIdx = PTR_W'(i);
      end
    end
  end

  assign fillIdx = cplAny ? cplIdx : rrPtr;

  // First free pending slot
  logic [PIDX_W-1:0] freeIdx;

  always_comb begin
    freeIdx = '0;
    for (int i = NUM_PEND - 1; i >= 0; i--) begin
      if (!pendValid[i]) freeIdx = PIDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      entNoX   <= '0;
      entR     <= '0;
      entW     <= '0;
      rrPtr    <= '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        entTag[i] <= '0;
        entPpn[i] <= '0;
      end
    end else if (strobe.clearAll) begin
      entValid <= '0;
      rrPtr    <= '0;
    end else if (strobe.install) begin
      entValid[fillIdx] <= 1'b1;
      entTag[fillIdx]   <= cplVpn;
      entPpn[fillIdx]   <= cplPpn;
      entNoX[fillIdx]   <= !cplOk;
      entR[fillIdx]     <= cplOk && cplRead;
      entW[fillIdx]     <= cplOk && cplWrite;
      if (!cplAny) begin
        rrPtr <= (rrPtr == PTR_W'(NUM_ENT - 1)) ? '0 : rrPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= '0;
      for (int i = 0; i < NUM_PEND; i++) pendVpn[i] <= '0;
    end else begin
      if (strobe.clearAll) begin
        pendValid <= '0;
      end else if (strobe.install) begin
        pendValid <= pendValid & ~pendCplMatch;
      end
      if (strobe.allocPend) begin
        pendValid[freeIdx] <= 1'b1;
        pendVpn[freeIdx]   <= reqVpn;
      end
    end
  end

  // Output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr       <= '0;
      outWrite      <= 1'b0;
      outTranslated <= 1'b0;
      xreqVpn       <= '0;
    end else begin
      if (strobe.accept) begin
        outAddr       <= strobe.useXlat ? {selPpn, reqAddr[OFF_W-1:0]} : reqAddr;
        outWrite      <= reqWrite;
        outTranslated <= strobe.useXlat;
      end
      if (strobe.issueXreq) begin
        xreqVpn <= reqVpn;
      end
    end
  end

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic         outReady,
  input  logic         xreqReady,
  input  logic         cplValid,
  input  logic         invalAll,
  input  logic         tagHit,
  input  logic         usable,
  input  logic         pendHit,
  input  logic         pendFull,
  output logic         outValid,
  output logic         xreqValid,
  output ctrl_strobe_t strobe
);

  logic outFree;
  logic xFree;
  logic accept;
  logic hitNow;
  logic pendNow;
  logic fullNow;
  logic issue;

  assign outFree  = !outValid || outReady;
  assign xFree    = !xreqValid || xreqReady;
  assign reqReady = outFree && xFree;
  assign accept   = reqValid && reqReady;

  // A same-cycle invalidate hides the whole cache and pending table
  assign hitNow  = tagHit && !invalAll;
  assign pendNow = pendHit && !invalAll;
  assign fullNow = pendFull && !invalAll;
  assign issue   = accept && !hitNow && !pendNow && !fullNow;

  always_comb begin
    strobe           = '0;
    strobe.accept    = accept;
    strobe.useXlat   = hitNow && usable;
    strobe.issueXreq = issue;
    strobe.allocPend = issue;
    strobe.install   = cplValid && !invalAll;
    strobe.clearAll  = invalAll;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      xreqValid <= 1'b0;
    end else begin
      if (accept) outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;
      if (issue) xreqValid <= 1'b1;
      else if (xreqReady) xreqValid <= 1'b0;
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned NUM_ENT  = 8,
  parameter int unsigned NUM_PEND = 4,
  parameter int unsigned PN_W     = 36,
  parameter int unsigned OFF_W    = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [PN_W+OFF_W-1:0] reqAddr,
  input  logic                  reqWrite,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [PN_W+OFF_W-1:0] outAddr,
  output logic                  outWrite,
  output logic                  outTranslated,
  output logic                  xreqValid,
  input  logic                  xreqReady,
  output logic [PN_W-1:0]       xreqVpn,
  input  logic                  cplValid,
  input  logic [PN_W-1:0]       cplVpn,
  input  logic                  cplOk,
  input  logic [PN_W-1:0]       cplPpn,
  input  logic                  cplRead,
  input  logic                  cplWrite,
  input  logic                  invalAll
);

  ctrl_strobe_t strobe;
  logic tagHit;
  logic usable;
  logic pendHit;
  logic pendFull;

  xlat_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .outReady  (outReady),
    .xreqReady (xreqReady),
    .cplValid  (cplValid),
    .invalAll  (invalAll),
    .tagHit    (tagHit),
    .usable    (usable),
    .pendHit   (pendHit),
    .pendFull  (pendFull),
    .outValid  (outValid),
    .xreqValid (xreqValid),
    .strobe    (strobe)
  );

  xlat_dp #(
    .NUM_ENT  (NUM_ENT),
    .NUM_PEND (NUM_PEND),
    .PN_W     (PN_W),
    .OFF_W    (OFF_W)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqAddr       (reqAddr),
    .reqWrite      (reqWrite),
    .cplVpn        (cplVpn),
    .cplOk         (cplOk),
    .cplPpn        (cplPpn),
    .cplRead       (cplRead),
    .cplWrite      (cplWrite),
    .tagHit        (tagHit),
    .usable        (usable),
    .pendHit       (pendHit),
    .pendFull      (pendFull),
    .outAddr       (outAddr),
    .outWrite      (outWrite),
    .outTranslated (outTranslated),
    .xreqVpn       (xreqVpn)
  );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int unsigned NUM_ENT = 8,
  parameter int unsigned PN_W    = 36,
  parameter int unsigned OFF_W   = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic                  reqReady,
  input logic                  outValid,
  input logic                  outReady,
  input logic [PN_W+OFF_W-1:0] outAddr,
  input logic                  outTranslated,
  input logic                  xreqValid,
  input logic                  xreqReady,
  input logic [PN_W-1:0]       xreqVpn,
  input logic                  invalAll,
  input logic [NUM_ENT-1:0]    entValid,
  input logic [NUM_ENT-1:0]    hitVec
);

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outAddr) && $stable(outTranslated)));

  assert_no_accept_when_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !reqReady);

  assert_xreq_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (xreqValid && !xreqReady) |=> (xreqValid && $stable(xreqVpn)));

  assert_xreq_from_request_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xreqValid) |-> $past(reqValid && reqReady));

  assert_inval_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    invalAll |=> (entValid == '0));

  assert_unique_tag_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

endmodule

bind xlat_cache xlat_cache_chk #(
  .NUM_ENT (NUM_ENT),
  .PN_W    (PN_W),
  .OFF_W   (OFF_W)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqReady      (reqReady),
  .outValid      (outValid),
  .outReady      (outReady),
  .outAddr       (outAddr),
  .outTranslated (outTranslated),
  .xreqValid     (xreqValid),
  .xreqReady     (xreqReady),
  .xreqVpn       (xreqVpn),
  .invalAll      (invalAll),
  .entValid      (dp_i.entValid),
  .hitVec        (dp_i.hitVec)
);

// File: tb/xlat_cache_tb_top.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;

  localparam int unsigned PN_W   = 36;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned ADDR_W = PN_W + OFF_W;
  localparam int unsigned NENT   = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqWrite = 1'b0;
  logic              outValid;
  logic              outReady = 1'b1;
  logic [ADDR_W-1:0] outAddr;
  logic              outWrite;
  logic              outTranslated;
  logic              xreqValid;
  logic              xreqReady = 1'b1;
  logic [PN_W-1:0]   xreqVpn;
  logic              cplValid = 1'b0;
  logic [PN_W-1:0]   cplVpn = '0;
  logic              cplOk = 1'b0;
  logic [PN_W-1:0]   cplPpn = '0;
  logic              cplRead = 1'b0;
  logic              cplWrite = 1'b0;
  logic              invalAll = 1'b0;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr), .outWrite(outWrite),
    .outTranslated(outTranslated),
    .xreqValid(xreqValid), .xreqReady(xreqReady), .xreqVpn(xreqVpn),
    .cplValid(cplValid), .cplVpn(cplVpn), .cplOk(cplOk), .cplPpn(cplPpn),
    .cplRead(cplRead), .cplWrite(cplWrite), .invalAll(invalAll)
  );

  function automatic logic [PN_W-1:0] ppnOf(input logic [PN_W-1:0] v);
    return v ^ 36'h0_F0F0_0F0F;
  endfunction

  function automatic logic [OFF_W-1:0] offOf(input int k);
    return OFF_W'((k * 419 + 7) & 12'hFFF);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doReq(input logic [PN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                       input logic wr, input logic inv);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = {vpn, off};
    reqWrite = wr;
    invalAll = inv;
    @(negedge clk);
    reqValid = 1'b0;
    invalAll = 1'b0;
  endtask

  task automatic doCpl(input logic [PN_W-1:0] vpn, input logic ok,
                       input logic [PN_W-1:0] ppn, input logic rd, input logic wr,
                       input logic inv);
    @(negedge clk);
    cplValid = 1'b1;
    cplVpn   = vpn;
    cplOk    = ok;
    cplPpn   = ppn;
    cplRead  = rd;
    cplWrite = wr;
    invalAll = inv;
    @(negedge clk);
    cplValid = 1'b0;
    invalAll = 1'b0;
  endtask

  task automatic doInval();
    @(negedge clk);
    invalAll = 1'b1;
    @(negedge clk);
    invalAll = 1'b0;
  endtask

  // Expect a translated forward with no host request
  task automatic expHit(input string tag, input logic [PN_W-1:0] ppn,
                        input logic [OFF_W-1:0] off);
    chk(tag, "outValid", 64'(outValid), 64'd1);
    chk(tag, "outAddr", 64'(outAddr), 64'({ppn, off}));
    chk(tag, "outTranslated", 64'(outTranslated), 64'd1);
    chk(tag, "xreqValid", 64'(xreqValid), 64'd0);
  endtask

  // Expect an untranslated forward; xr tells whether a host request must appear
  task automatic expMiss(input string tag, input logic [PN_W-1:0] vpn,
                         input logic [OFF_W-1:0] off, input logic xr);
    chk(tag, "outValid", 64'(outValid), 64'd1);
    chk(tag, "outAddr", 64'(outAddr), 64'({vpn, off}));
    chk(tag, "outTranslated", 64'(outTranslated), 64'd0);
    chk(tag, "xreqValid", 64'(xreqValid), 64'(xr));
    if (xr) chk(tag, "xreqVpn", 64'(xreqVpn), 64'(vpn));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "outValid", 64'(outValid), 64'd0);
    chk("R1", "xreqValid", 64'(xreqValid), 64'd0);
    chk("R1", "reqReady", 64'(reqReady), 64'd1);

    // R3: first miss raises a host request; R1: empty cache means miss
    doReq(36'h5, 12'h123, 1'b0, 1'b0);
    expMiss("R3", 36'h5, 12'h123, 1'b1);
    chk("R3", "outWrite", 64'(outWrite), 64'd0);
    // R4: second miss while pending raises no request
    doReq(36'h5, 12'h456, 1'b1, 1'b0);
    expMiss("R4", 36'h5, 12'h456, 1'b0);
    chk("R4", "outWrite", 64'(outWrite), 64'd1);
    // R2: completion installs, later requests translate
    doCpl(36'h5, 1'b1, ppnOf(36'h5), 1'b1, 1'b1, 1'b0);
    doReq(36'h5, 12'hABC, 1'b0, 1'b0);
    expHit("R2", ppnOf(36'h5), 12'hABC);
    doReq(36'h5, 12'h001, 1'b1, 1'b0);
    expHit("R2", ppnOf(36'h5), 12'h001);

    // R5: failed completion recorded, no retry
    doReq(36'h7, 12'h010, 1'b0, 1'b0);
    expMiss("R5", 36'h7, 12'h010, 1'b1);
    doCpl(36'h7, 1'b0, ppnOf(36'h7), 1'b1, 1'b1, 1'b0);
    doReq(36'h7, 12'h020, 1'b0, 1'b0);
    expMiss("R5", 36'h7, 12'h020, 1'b0);
    doReq(36'h7, 12'h030, 1'b1, 1'b0);
    expMiss("R5", 36'h7, 12'h030, 1'b0);

    // R6: permission checks
    doCpl(36'h9, 1'b1, ppnOf(36'h9), 1'b1, 1'b0, 1'b0);
    doCpl(36'hA, 1'b1, ppnOf(36'hA), 1'b0, 1'b1, 1'b0);
    doReq(36'h9, 12'h044, 1'b1, 1'b0);
    expMiss("R6", 36'h9, 12'h044, 1'b0);
    doReq(36'h9, 12'h055, 1'b0, 1'b0);
    expHit("R6", ppnOf(36'h9), 12'h055);
    doReq(36'hA, 12'h066, 1'b0, 1'b0);
    expMiss("R6", 36'hA, 12'h066, 1'b0);
    doReq(36'hA, 12'h077, 1'b1, 1'b0);
    expHit("R6", ppnOf(36'hA), 12'h077);

    // R9: invalidate empties the cache
    doInval();
    doReq(36'h5, 12'h100, 1'b0, 1'b0);
    expMiss("R9", 36'h5, 12'h100, 1'b1);
    // R9: invalidate clears pending, so the page is requested again
    doReq(36'h33, 12'h200, 1'b0, 1'b0);
    expMiss("R9", 36'h33, 12'h200, 1'b1);
    doInval();
    doReq(36'h33, 12'h201, 1'b0, 1'b0);
    expMiss("R9", 36'h33, 12'h201, 1'b1);
    // R9: completion in the invalidate cycle is discarded
    doCpl(36'h44, 1'b1, ppnOf(36'h44), 1'b1, 1'b1, 1'b1);
    doReq(36'h44, 12'h300, 1'b0, 1'b0);
    expMiss("R9", 36'h44, 12'h300, 1'b1);
    // R9: request in the invalidate cycle misses
    doCpl(36'h55, 1'b1, ppnOf(36'h55), 1'b1, 1'b1, 1'b0);
    doReq(36'h55, 12'h400, 1'b0, 1'b0);
    expHit("R9", ppnOf(36'h55), 12'h400);
    doReq(36'h55, 12'h401, 1'b0, 1'b1);
    expMiss("R9", 36'h55, 12'h401, 1'b1);

    // R8: round-robin sweep over every entry, then wrap
    doInval();
    for (int i = 0; i <= NENT; i++) begin
      doCpl(PN_W'(36'h100 + i), 1'b1, ppnOf(PN_W'(36'h100 + i)), 1'b1, 1'b1, 1'b0);
    end
    for (int i = 1; i <= NENT; i++) begin
      doReq(PN_W'(36'h100 + i), offOf(i), i[0], 1'b0);
      expHit("R8", ppnOf(PN_W'(36'h100 + i)), offOf(i));
    end
    doReq(36'h100, 12'hFFF, 1'b0, 1'b0);
    expMiss("R8", 36'h100, 12'hFFF, 1'b1);

    // R7: update in place, nothing evicted
    doCpl(36'h103, 1'b1, 36'h0_DEAD_BEEF, 1'b1, 1'b1, 1'b0);
    for (int i = 1; i <= NENT; i++) begin
      doReq(PN_W'(36'h100 + i), offOf(i + 20), 1'b0, 1'b0);
      expHit("R7", (i == 3) ? 36'h0_DEAD_BEEF : ppnOf(PN_W'(36'h100 + i)), offOf(i + 20));
    end

    // R10 / R11: backpressure on both outputs
    @(negedge clk);
    outReady  = 1'b0;
    xreqReady = 1'b0;
    doReq(36'h200, 12'h0AA, 1'b1, 1'b0);
    expMiss("R10", 36'h200, 12'h0AA, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10", "reqReady", 64'(reqReady), 64'd0);
      chk("R10", "outValid", 64'(outValid), 64'd1);
      chk("R10", "outAddr", 64'(outAddr), 64'({36'h200, 12'h0AA}));
      chk("R11", "xreqValid", 64'(xreqValid), 64'd1);
      chk("R11", "xreqVpn", 64'(xreqVpn), 64'h200);
    end
    outReady  = 1'b1;
    xreqReady = 1'b1;
    @(negedge clk);
    chk("R10", "outValid", 64'(outValid), 64'd0);
    chk("R11", "xreqValid", 64'(xreqValid), 64'd0);
    chk("R10", "reqReady", 64'(reqReady), 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule